// File: doc/BRIEF.md
# Associative Memory Road Matcher

The block keeps a bank of stored track patterns. Each pattern has one coarse-position word for each detector layer. Hits arrive one per cycle. Each hit carries a layer number and a coarse-position word, and it is compared with every stored pattern in the same cycle. When a pattern's word for that layer equals the hit word, the pattern sets that layer's match bit and keeps it for the rest of the event. A pattern fires when the number of its matched layers reaches a programmable threshold, so a track with a missing or noisy layer can still be found.

An end-of-event marker on the hit stream closes the event. The set of fired patterns is captured in the same cycle, and all match bits are cleared. The addresses of the fired patterns, called roads, then appear on the output stream in ascending order, and one end word follows them. No search time is needed after the last hit. During readout the hit stream is held off. Pattern words and the threshold can be changed only while the block is collecting hits.

Top module: `am_matcher`

## Requirements
- R1: After reset, hit_ready_o is 1, road_valid_o is 0, and the majority threshold is 5.
- R2: When load_en_i is high in the collecting state, load_word_i is written into layer load_layer_i of pattern load_pat_i. A load with load_layer_i >= 6 is ignored. Loads and threshold writes are ignored during readout.
- R3: Take an accepted hit beat with hit_eoe_i = 0 and hit_layer_i < 6. It sets the match bit for that layer in every pattern whose stored word on that layer equals hit_word_i. Repeated matches on the same layer count once. A hit with hit_layer_i >= 6 has no effect.
- R4: A pattern fires when its count of set layer bits is >= the threshold. A thr_we_i pulse in the collecting state loads thr_i. A threshold of 0 fires all 128 patterns, and a threshold of 7 fires none.
- R5: The cycle after a marker beat is accepted (hit_valid_i = 1, hit_eoe_i = 1, hit_ready_o = 1), road_valid_o is 1. Each fired pattern address then appears exactly once, in strictly ascending order.
- R6: After the last road, one end word is presented with road_last_o = 1 and road_addr_o = 0. While road_ready_i is low, every output beat holds its value.
- R7: hit_ready_o is 0 from the cycle after the marker is accepted until the end word is taken, and it is 1 in the cycle after that. hit_ready_o and road_valid_o are never both high.
- R8: The match bits of all patterns are cleared when the marker is accepted, so no match carries over into the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_en_i | input | 1 | Pattern word write strobe |
| load_pat_i | input | 7 | Pattern address to write |
| load_layer_i | input | 3 | Layer of the word to write |
| load_word_i | input | 12 | Coarse-position word to store |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_i | input | 3 | New majority threshold |
| hit_valid_i | input | 1 | Hit beat valid |
| hit_ready_o | output | 1 | Hit beat accepted when high |
| hit_eoe_i | input | 1 | Beat is the end-of-event marker (layer and word ignored) |
| hit_layer_i | input | 3 | Layer of the hit |
| hit_word_i | input | 12 | Coarse-position word of the hit |
| road_valid_o | output | 1 | Road beat valid |
| road_ready_i | input | 1 | Road beat taken when high with valid |
| road_addr_o | output | 7 | Fired pattern address |
| road_last_o | output | 1 | End word of the event |

## Verification
The hardest case to reach is a load or threshold write that arrives during readout. It must leave the bank untouched, yet its effect can only show up in a later event. The bench tries such a write while roads are being stalled by road_ready_i. It then runs an event that fires only if the original word and threshold survived. Events whose hits are split across layers check that match bits do not carry over from one event to the next. Thresholds of 0 and 7 drive the scan to a full bank and to an empty one.

// File: rtl/am_pkg.sv
package am_pkg;
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_READOUT = 1'b1
  } am_state_e;
endpackage

// File: rtl/am_pattern_cell.sv
module am_pattern_cell #(
  parameter int NUM_LAYER = 6,
  parameter int WORD_W    = 12,
  parameter int LAY_W     = 3,
  parameter int THR_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [LAY_W-1:0]  wr_layer_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              hit_en_i,
  input  logic [LAY_W-1:0]  hit_layer_i,
  input  logic [WORD_W-1:0] hit_word_i,
  input  logic              clr_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic              fired_o
);
  logic [NUM_LAYER-1:0] match_w;
  logic [THR_W-1:0]     cnt;

  for (genvar l = 0; l < NUM_LAYER; l++) begin : g_lay
    logic [WORD_W-1:0] word_q;
    logic              m_q;

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_layer_i == LAY_W'(l)) word_q <= wr_word_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                                   m_q <= 1'b0;
      else if (clr_i)                                                m_q <= 1'b0;
      else if (hit_en_i && hit_layer_i == LAY_W'(l) && hit_word_i == word_q) m_q <= 1'b1;
    end

    assign match_w[l] = m_q;
  end

  always_comb begin
    cnt = '0;
    for (int l = 0; l < NUM_LAYER; l++) cnt = cnt + THR_W'(match_w[l]);
  end

  assign fired_o = (cnt >= thr_i);
endmodule

// File: rtl/am_road_scan.sv
module am_road_scan #(
  parameter int NUM_PAT = 128,
  parameter int PAT_AW  = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic [NUM_PAT-1:0] fired_i,
  input  logic               road_ready_i,
  output logic               valid_o,
  output logic [PAT_AW-1:0]  addr_o,
  output logic               last_o,
  output logic               done_o
);
  logic [NUM_PAT-1:0] pending_q;
  logic               active_q;
  logic [PAT_AW-1:0]  idx;
  logic               any;

  // lowest set bit wins -> ascending readout
  always_comb begin
    idx = '0;
    for (int i = NUM_PAT - 1; i >= 0; i--) begin
      if (pending_q[i]) idx = PAT_AW'(i);
    end
  end

  assign any     = |pending_q;
  assign valid_o = active_q;
  assign last_o  = active_q && !any;
  assign addr_o  = any ? idx : '0;
  assign done_o  = active_q && road_ready_i && !any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= '0;
      active_q  <= 1'b0;
    end else if (capture_i) begin
      pending_q <= fired_i;
      active_q  <= 1'b1;
    end else if (active_q && road_ready_i) begin
      if (any) pending_q[idx] <= 1'b0;
      else     active_q       <= 1'b0;
    end
  end
endmodule

// File: rtl/am_matcher.sv
module am_matcher
  import am_pkg::*;
#(
  parameter int NUM_PAT   = 128,
  parameter int NUM_LAYER = 6,
  parameter int WORD_W    = 12,
  parameter int DEF_THR   = 5,
  localparam int PAT_AW   = $clog2(NUM_PAT),
  localparam int LAY_W    = $clog2(NUM_LAYER),
  localparam int THR_W    = $clog2(NUM_LAYER + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [PAT_AW-1:0] load_pat_i,
  input  logic [LAY_W-1:0]  load_layer_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              thr_we_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic              hit_valid_i,
  output logic              hit_ready_o,
  input  logic              hit_eoe_i,
  input  logic [LAY_W-1:0]  hit_layer_i,
  input  logic [WORD_W-1:0] hit_word_i,
  output logic              road_valid_o,
  input  logic              road_ready_i,
  output logic [PAT_AW-1:0] road_addr_o,
  output logic              road_last_o
);
  am_state_e          state_q;
  logic [THR_W-1:0]   thr_q;
  logic               collect, hit_fire, eoe_acc, hit_acc, wr_en, scan_done;
  logic [NUM_PAT-1:0] fired;

  assign collect     = (state_q == ST_COLLECT);
  assign hit_ready_o = collect;
  assign hit_fire    = hit_valid_i && collect;
  assign eoe_acc     = hit_fire && hit_eoe_i;
  assign hit_acc     = hit_fire && !hit_eoe_i &&
                       ({1'b0, hit_layer_i} < (LAY_W + 1)'(NUM_LAYER));
  assign wr_en       = load_en_i && collect &&
                       ({1'b0, load_layer_i} < (LAY_W + 1)'(NUM_LAYER));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COLLECT;
      thr_q   <= THR_W'(DEF_THR);
    end else begin
      if (thr_we_i && collect) thr_q <= thr_i;
      case (state_q)
        ST_COLLECT: if (eoe_acc)   state_q <= ST_READOUT;
        ST_READOUT: if (scan_done) state_q <= ST_COLLECT;
        default:                   state_q <= ST_COLLECT;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    am_pattern_cell #(
      .NUM_LAYER(NUM_LAYER), .WORD_W(WORD_W), .LAY_W(LAY_W), .THR_W(THR_W)
    ) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en && load_pat_i == PAT_AW'(p)),
      .wr_layer_i (load_layer_i),
      .wr_word_i  (load_word_i),
      .hit_en_i   (hit_acc),
      .hit_layer_i(hit_layer_i),
      .hit_word_i (hit_word_i),
      .clr_i      (eoe_acc),
      .thr_i      (thr_q),
      .fired_o    (fired[p])
    );
  end

  am_road_scan #(.NUM_PAT(NUM_PAT), .PAT_AW(PAT_AW)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .capture_i   (eoe_acc),
    .fired_i     (fired),
    .road_ready_i(road_ready_i),
    .valid_o     (road_valid_o),
    .addr_o      (road_addr_o),
    .last_o      (road_last_o),
    .done_o      (scan_done)
  );
endmodule

// File: rtl/am_matcher_chk.sv
module am_matcher_chk #(
  parameter int PAT_AW = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hit_valid_i,
  input logic              hit_ready_o,
  input logic              hit_eoe_i,
  input logic              road_valid_o,
  input logic              road_ready_i,
  input logic [PAT_AW-1:0] road_addr_o,
  input logic              road_last_o
);
  logic [PAT_AW-1:0] prev_addr_q;
  logic              prev_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_addr_q <= '0;
      prev_ok_q   <= 1'b0;
    end else if (road_valid_o && road_ready_i) begin
      prev_addr_q <= road_addr_o;
      prev_ok_q   <= !road_last_o;
    end
  end

  // R7
  excl_ready_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_ready_o && road_valid_o));

  // R6
  road_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    road_valid_o && !road_ready_i |=> road_valid_o && $stable(road_addr_o) && $stable(road_last_o));

  // R5
  ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    road_valid_o && !road_last_o && prev_ok_q |-> road_addr_o > prev_addr_q);

  // R5
  readout_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_i && hit_ready_o && hit_eoe_i |=> road_valid_o);

  // R7
  resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    road_valid_o && road_ready_i && road_last_o |=> hit_ready_o && !road_valid_o);

  // R6
  end_word_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    road_valid_o && road_last_o |-> road_addr_o == '0);
endmodule

bind am_matcher am_matcher_chk #(.PAT_AW(PAT_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hit_valid_i (hit_valid_i),
  .hit_ready_o (hit_ready_o),
  .hit_eoe_i   (hit_eoe_i),
  .road_valid_o(road_valid_o),
  .road_ready_i(road_ready_i),
  .road_addr_o (road_addr_o),
  .road_last_o (road_last_o)
);

// File: tb/am_matcher_test.sv
`timescale 1ns/1ps
module am_matcher_test;
  localparam int NP = 128;
  localparam int NL = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_en_i = 1'b0;
  logic [6:0]  load_pat_i = '0;
  logic [2:0]  load_layer_i = '0;
  logic [11:0] load_word_i = '0;
  logic        thr_we_i = 1'b0;
  logic [2:0]  thr_i = '0;
  logic        hit_valid_i = 1'b0;
  logic        hit_ready_o;
  logic        hit_eoe_i = 1'b0;
  logic [2:0]  hit_layer_i = '0;
  logic [11:0] hit_word_i = '0;
  logic        road_valid_o;
  logic        road_ready_i = 1'b0;
  logic [6:0]  road_addr_o;
  logic        road_last_o;

  am_matcher uut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  logic [11:0] mem_m [NP][NL];
  logic [NL-1:0] mask_m [NP];
  int thr_m = 5;
  int exp_q[$];
  int got_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int p, input int l, input logic [11:0] w);
    @(negedge clk_i);
    load_en_i = 1'b1; load_pat_i = 7'(p); load_layer_i = 3'(l); load_word_i = w;
    @(negedge clk_i);
    load_en_i = 1'b0;
    if (l < NL) mem_m[p][l] = w;
  endtask

  task automatic set_thr(input int t);
    @(negedge clk_i);
    thr_we_i = 1'b1; thr_i = 3'(t);
    @(negedge clk_i);
    thr_we_i = 1'b0;
    thr_m = t;
  endtask

  task automatic beat(input bit eoe, input int l, input logic [11:0] w);
    @(negedge clk_i);
    hit_valid_i = 1'b1; hit_eoe_i = eoe; hit_layer_i = 3'(l); hit_word_i = w;
    while (!hit_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1 hit_valid_i = 1'b0; hit_eoe_i = 1'b0;
  endtask

  task automatic hit(input int l, input logic [11:0] w);
    beat(1'b0, l, w);
    if (l < NL)
      for (int p = 0; p < NP; p++)
        if (mem_m[p][l] == w) mask_m[p][l] = 1'b1;
  endtask

  // marker + readout; optional load/threshold write attempt during readout
  task automatic end_event(input string req, input bit intrude, input int stall_pct);
    bit done;
    bit first;
    exp_q.delete(); got_q.delete();
    for (int p = 0; p < NP; p++)
      if ($countones(mask_m[p]) >= thr_m) exp_q.push_back(p);
    beat(1'b1, 0, 12'h0);
    @(negedge clk_i);
    check(road_valid_o === 1'b1, "R5 road_valid one cycle after marker", int'(road_valid_o), 1);
    check(hit_ready_o === 1'b0, "R7 hit_ready low in readout", int'(hit_ready_o), 0);
    if (intrude) begin
      load_en_i = 1'b1; load_pat_i = 7'd0; load_layer_i = 3'd0; load_word_i = 12'h900;
      thr_we_i = 1'b1; thr_i = 3'd0;
    end
    done = 1'b0;
    first = 1'b1;
    while (!done) begin
      if (!first) @(negedge clk_i);
      first = 1'b0;
      if (!intrude || !load_en_i) road_ready_i = (($urandom % 100) >= stall_pct);
      else road_ready_i = 1'b0;
      if (road_valid_o && road_ready_i) begin
        if (road_last_o) begin
          check(road_addr_o == 7'd0, "R6 end word address", int'(road_addr_o), 0);
          done = 1'b1;
        end else got_q.push_back(int'(road_addr_o));
      end
      if (intrude && load_en_i && !road_ready_i) begin
        @(negedge clk_i);
        load_en_i = 1'b0; thr_we_i = 1'b0;
        first = 1'b1;
      end
    end
    @(negedge clk_i);
    road_ready_i = 1'b0;
    check(hit_ready_o === 1'b1 && road_valid_o === 1'b0, "R7 hit_ready back after end word",
          int'(hit_ready_o), 1);
    check(got_q.size() == exp_q.size(), {req, " road count"}, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++)
        if (got_q[i] != exp_q[i]) begin
          check(1'b0, {req, " road address"}, got_q[i], exp_q[i]);
          break;
        end
    for (int p = 0; p < NP; p++) mask_m[p] = '0;
  endtask

  initial begin
    int guard = 0;
    while (guard < 150000) begin
      @(posedge clk_i);
      guard++;
    end
    failures++;
    $display("FAIL R7 watchdog actual=hang expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20011));
    for (int p = 0; p < NP; p++) mask_m[p] = '0;
    #7 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(hit_ready_o === 1'b1, "R1 hit_ready after reset", int'(hit_ready_o), 1);
    check(road_valid_o === 1'b0, "R1 road_valid after reset", int'(road_valid_o), 0);

    // R2 fill bank with a small alphabet so random matches are common
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < NL; l++) load(p, l, 12'($urandom % 4));
    for (int l = 0; l < NL; l++) load(0, l, 12'h800 + 12'(l));

    // R1 default threshold 5: five of six layers fire pattern 0
    for (int l = 0; l < 5; l++) hit(l, 12'h800 + 12'(l));
    end_event("R1 default threshold", 1'b0, 30);

    // R3 duplicates and out-of-range layer do not add layers
    set_thr(6);
    for (int l = 0; l < 5; l++) hit(l, 12'h800 + 12'(l));
    hit(0, 12'h800); hit(0, 12'h800);
    hit(7, 12'h805); hit(6, 12'h805);
    end_event("R3 duplicate and bad layer", 1'b0, 30);

    // R2 write attempts during readout are ignored
    for (int l = 0; l < NL; l++) hit(l, 12'h800 + 12'(l));
    end_event("R4 full match", 1'b1, 0);
    for (int l = 0; l < NL; l++) hit(l, 12'h800 + 12'(l));
    end_event("R2 load during readout ignored", 1'b0, 20);

    // R2 load to layer 6 is dropped
    load(0, 6, 12'h123);
    for (int l = 0; l < NL; l++) hit(l, 12'h800 + 12'(l));
    end_event("R2 layer 6 load ignored", 1'b0, 20);

    // R8 flags cleared across events
    for (int l = 0; l < 3; l++) hit(l, 12'h800 + 12'(l));
    end_event("R8 first half", 1'b0, 10);
    for (int l = 3; l < NL; l++) hit(l, 12'h800 + 12'(l));
    end_event("R8 second half no carry", 1'b0, 10);

    // R4 threshold extremes
    set_thr(0);
    end_event("R4 threshold 0 all fire", 1'b0, 40);
    set_thr(7);
    for (int l = 0; l < NL; l++) hit(l, 12'h800 + 12'(l));
    end_event("R4 threshold 7 none", 1'b0, 40);

    // R3 R4 R5 random events
    for (int e = 0; e < 25; e++) begin
      set_thr(3 + int'($urandom % 4));
      for (int h = 0; h < 4 + int'($urandom % 12); h++)
        hit(int'($urandom % 8), 12'($urandom % 4));
      end_event("R3 R4 R5 random event", 1'b0, int'($urandom % 60));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule